// File: doc/BRIEF.md
# PHY Test-Port Register Writer

This block writes one 8-bit configuration register inside a PHY through the PHY's serial test port. The test port has a test clock, a test enable and an 8-bit test data bus. A controller hands the block a register code, a data byte and a hold length through a valid/ready handshake. The block then drives the test-port pins through a fixed sequence of seven steps. The PHY takes the code on a falling test-clock edge while test enable is high. It stores the data byte on the next rising test-clock edge, taken while test enable is low.

Each step is held for a number of system clock cycles that the requester chooses. This lets slow PHY setup and hold times be met without changing the design. A one-cycle completion pulse marks the end of every write. A new request can be accepted in that same cycle, so several writes can run back to back.

Top module: `tport_writer`

## Requirements
- R1: While reset is high, and in the first cycle after it, the port drives test clock 1, test enable 0 and test data 0x00, with ready high and done low. Reset in the middle of a write abandons the write.
- R2: A request is accepted on a rising clock edge where valid and ready are both high. Code, data and hold length are captured at that edge, and later changes to these inputs have no effect on the write.
- R3: The pins step through seven steps, numbered from 0:
  - step 0: clock is 1, and enable and data are unchanged;
  - step 1: data becomes the code, with clock 1 and enable 0;
  - step 2: enable becomes 1;
  - step 3: clock becomes 0;
  - step 4: enable becomes 0;
  - step 5: data becomes the data byte;
  - step 6: clock becomes 1.
- R4: Each step lasts max(hold,1) system clock cycles. A hold length of 0 behaves as 1. Step 0 appears in the first cycle after the accepting edge.
- R5: Ready is low for exactly 7*max(hold,1) cycles after the accepting edge, and only during that time.
- R6: Done is high for exactly one cycle, in the first cycle after ready goes low for a write ends. Ready is already high in that cycle, so a request presented then is accepted at the next edge.
- R7: A PHY that latches the code on a falling test-clock edge with enable 1, and writes on a rising edge with enable 0, sees exactly one code latch and one write per transfer, and the write puts the requested data at the requested code. Afterwards the port rests at test clock 1, enable 0 and data equal to the data byte.
- R8: A valid request presented while ready is low is not accepted. It starts no transfer and writes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_code | input | 8 | PHY register code to write |
| req_data | input | 8 | Byte to store in that register |
| req_hold | input | HOLD_W | Cycles each step is held (0 means 1) |
| done | output | 1 | One-cycle pulse at the end of a write |
| tp_clk | output | 1 | PHY test clock |
| tp_en | output | 1 | PHY test enable |
| tp_din | output | 8 | PHY test data input bus |

## Verification
The completion pulse of one write and the acceptance of the next request can land in the same cycle. The bench provokes this by holding valid high with a fresh request at the exact cycle where done appears. It then judges the second transfer by its full pin sequence and busy length, and by a model PHY that must see exactly one code latch and one commit per write. A second case keeps valid high with different values for the whole busy window. It then confirms that no extra transfer starts when ready returns and that the stray register code stays unwritten.

// File: rtl/tport_pkg.sv
package tport_pkg;

    localparam int PORT_W    = 8;
    localparam int NUM_STEPS = 7;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [STEP_W-1:0] {
        ST_CLK_HI   = 3'd0,
        ST_DIN_CODE = 3'd1,
        ST_EN_HI    = 3'd2,
        ST_CLK_LO   = 3'd3,
        ST_EN_LO    = 3'd4,
        ST_DIN_DATA = 3'd5,
        ST_CLK_RISE = 3'd6
    } step_e;

    typedef struct packed {
        logic              tclk;
        logic              ten;
        logic [PORT_W-1:0] tdin;
    } port_t;

    typedef struct packed {
        logic [PORT_W-1:0] code;
        logic [PORT_W-1:0] data;
    } req_t;

    localparam port_t PORT_IDLE = '{tclk: 1'b1, ten: 1'b0, tdin: '0};

    // Pin state after applying one step to the current pin state
    function automatic port_t apply_step(step_e s, port_t cur, req_t rq);
        port_t nxt;
        nxt = cur;
        case (s)
            ST_CLK_HI:   nxt.tclk = 1'b1;
            ST_DIN_CODE: nxt.tdin = rq.code;
            ST_EN_HI:    nxt.ten  = 1'b1;
            ST_CLK_LO:   nxt.tclk = 1'b0;
            ST_EN_LO:    nxt.ten  = 1'b0;
            ST_DIN_DATA: nxt.tdin = rq.data;
            ST_CLK_RISE: nxt.tclk = 1'b1;
            default:     nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tport_hold.sv
module tport_hold #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              expired
);
    logic [HOLD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/tport_seq.sv
module tport_seq
    import tport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  expired,
    output logic  busy,
    output logic  advance,
    output step_e next_step,
    output logic  done
);
    step_e step;
    logic  last;
    logic  finish;

    assign last      = (step == ST_CLK_RISE);
    assign finish    = busy & expired & last;
    assign advance   = start | (busy & expired & ~last);
    assign next_step = start ? ST_CLK_HI : step_e'(step + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            step <= ST_CLK_HI;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (start) begin
                busy <= 1'b1;
                step <= ST_CLK_HI;
            end else if (finish) begin
                busy <= 1'b0;
            end else if (advance) begin
                step <= next_step;
            end
        end
    end
endmodule

// File: rtl/tport_drive.sv
module tport_drive
    import tport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  apply,
    input  step_e sel,
    input  req_t  rq,
    output port_t port
);
    always_ff @(posedge clk) begin
        if (rst)
            port <= PORT_IDLE;
        else if (apply)
            port <= apply_step(sel, port, rq);
    end
endmodule

// File: rtl/tport_writer.sv
module tport_writer
    import tport_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PORT_W-1:0] req_code,
    input  logic [PORT_W-1:0] req_data,
    input  logic [HOLD_W-1:0] req_hold,
    output logic              done,
    output logic              tp_clk,
    output logic              tp_en,
    output logic [PORT_W-1:0] tp_din
);
    logic              busy;
    logic              start;
    logic              advance;
    logic              expired;
    step_e             next_step;
    req_t              held_req;
    req_t              in_req;
    req_t              cur_req;
    logic [HOLD_W-1:0] held_len;
    logic [HOLD_W-1:0] in_len;
    logic [HOLD_W-1:0] load_len;
    port_t             port;

    assign req_ready = ~busy;
    assign start     = req_valid & ~busy;
    assign in_req    = '{code: req_code, data: req_data};
    // Hold counter is loaded with cycles-1; a zero length acts as one
    assign in_len    = (req_hold == '0) ? '0 : req_hold - 1'b1;
    assign cur_req   = start ? in_req : held_req;
    assign load_len  = start ? in_len : held_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_req <= '0;
            held_len <= '0;
        end else if (start) begin
            held_req <= in_req;
            held_len <= in_len;
        end
    end

    tport_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (advance),
        .load_val (load_len),
        .expired  (expired)
    );

    tport_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .expired   (expired),
        .busy      (busy),
        .advance   (advance),
        .next_step (next_step),
        .done      (done)
    );

    tport_drive u_drive (
        .clk   (clk),
        .rst   (rst),
        .apply (advance),
        .sel   (next_step),
        .rq    (cur_req),
        .port  (port)
    );

    assign tp_clk = port.tclk;
    assign tp_en  = port.ten;
    assign tp_din = port.tdin;
endmodule

// File: rtl/tport_writer_chk.sv
module tport_writer_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       tp_clk,
    input logic       tp_en,
    input logic [7:0] tp_din
);
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tp_clk && !tp_en && tp_din == 8'h00 && req_ready && !done));

    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_single_pin_move: assert property (@(posedge clk) disable iff (rst)
        $countones({tp_clk != $past(tp_clk), tp_en != $past(tp_en)}) <= 1);

    a_r3_en_moves_clk_low: assert property (@(posedge clk) disable iff (rst)
        $fell(tp_en) |-> !tp_clk);

    a_r5_ready_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> done);

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_latch_edge_en_high: assert property (@(posedge clk) disable iff (rst)
        $fell(tp_clk) |-> tp_en);

    a_r7_commit_edge_en_low: assert property (@(posedge clk) disable iff (rst)
        $rose(tp_clk) |-> !tp_en);

    a_r7_idle_pins: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (tp_clk && !tp_en));
endmodule

bind tport_writer tport_writer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .tp_clk    (tp_clk),
    .tp_en     (tp_en),
    .tp_din    (tp_din)
);

// File: tb/sim_tport_writer.sv
`timescale 1ns/1ps
module sim_tport_writer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_code = 8'h00;
    logic [7:0] req_data = 8'h00;
    logic [7:0] req_hold = 8'h01;
    logic       done;
    logic       tp_clk;
    logic       tp_en;
    logic [7:0] tp_din;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tport_writer #(.HOLD_W(8)) u0 (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_code  (req_code),
        .req_data  (req_data),
        .req_hold  (req_hold),
        .done      (done),
        .tp_clk    (tp_clk),
        .tp_en     (tp_en),
        .tp_din    (tp_din)
    );

    // Behavioural PHY register model
    logic [7:0] phy_regs [256];
    logic [7:0] phy_code = 8'h00;
    int latch_cnt  = 0;
    int commit_cnt = 0;

    always @(negedge tp_clk) if (!rst && tp_en === 1'b1) begin
        phy_code = tp_din;
        latch_cnt++;
    end

    always @(posedge tp_clk) if (!rst && tp_en === 1'b0) begin
        phy_regs[phy_code] = tp_din;
        commit_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // {hold, code, data}
    localparam logic [23:0] VEC [6] = '{
        {8'd1, 8'h44, 8'hA5},
        {8'd2, 8'h54, 8'h3C},
        {8'd3, 8'h84, 8'h0F},
        {8'd0, 8'h94, 8'hF0},
        {8'd5, 8'h75, 8'h04},
        {8'd4, 8'h34, 8'h81}
    };

    // Caller stands at a negedge; returns at the negedge where done is seen
    task automatic xfer(input logic [7:0] c, input logic [7:0] d,
                        input logic [7:0] h, input bit keep_valid);
        int heff;
        int n;
        int bad;
        int lc0;
        int cc0;
        logic [7:0] prev;
        heff = (h == 8'd0) ? 1 : int'(h);
        n    = 0;
        bad  = 0;
        lc0  = latch_cnt;
        cc0  = commit_cnt;
        prev = tp_din;
        chk(req_ready === 1'b1, "R2", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_code  = c;
        req_data  = d;
        req_hold  = h;
        @(negedge clk);
        // R2: later input changes must not matter
        req_code  = ~c;
        req_data  = d ^ 8'h5A;
        req_hold  = h + 8'd3;
        req_valid = keep_valid;
        while (req_ready !== 1'b1 && n < 4000) begin
            int s;
            logic e_clk;
            logic e_en;
            logic [7:0] e_din;
            s     = n / heff;
            e_clk = !(s == 3 || s == 4 || s == 5);
            e_en  = (s == 2 || s == 3);
            e_din = (s == 0) ? prev : ((s < 5) ? c : d);
            if (tp_clk !== e_clk || tp_en !== e_en || tp_din !== e_din || done !== 1'b0)
                bad++;
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(bad == 0, "R3", "pin sequence mismatches", bad, 0);
        chk(n == 7 * heff, "R4", "busy cycles", n, 7 * heff);
        chk(done === 1'b1, "R6", "done when ready returns", int'(done), 1);
        chk(phy_regs[c] == d, "R7", "register content", int'(phy_regs[c]), int'(d));
        chk((latch_cnt - lc0) == 1 && (commit_cnt - cc0) == 1, "R7",
            "latch+commit count", (latch_cnt - lc0) * 16 + (commit_cnt - cc0), 17);
        chk(tp_clk === 1'b1 && tp_en === 1'b0 && tp_din === d, "R7", "rest pins",
            int'({tp_clk, tp_en, tp_din}), int'({1'b1, 1'b0, d}));
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) phy_regs[i] = 8'h00;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tp_clk === 1'b1 && tp_en === 1'b0 && tp_din === 8'h00, "R1", "pins in reset",
            int'({tp_clk, tp_en, tp_din}), 'h200);
        chk(req_ready === 1'b1 && done === 1'b0, "R1", "ready/done in reset",
            int'({req_ready, done}), 2);
        rst = 1'b0;
        @(negedge clk);
        chk(tp_clk === 1'b1 && tp_en === 1'b0 && tp_din === 8'h00 && req_ready === 1'b1,
            "R1", "first cycle after reset", int'({tp_clk, tp_en, tp_din}), 'h200);

        // Vector table: R3 R4 R5 R7 across hold lengths, including 0
        for (int v = 0; v < 6; v++) begin
            xfer(VEC[v][15:8], VEC[v][7:0], VEC[v][23:16], 1'b0);
            @(negedge clk);
            chk(done === 1'b0, "R6", "done lasts one cycle", int'(done), 0);
            chk(req_ready === 1'b1, "R5", "ready stays high when idle", int'(req_ready), 1);
        end

        // R6: new request accepted in the done cycle
        xfer(8'h20, 8'h11, 8'd2, 1'b0);
        xfer(8'h21, 8'h22, 8'd1, 1'b0);
        @(negedge clk);
        chk(phy_regs[8'h20] == 8'h11, "R6", "first of back-to-back kept",
            int'(phy_regs[8'h20]), 'h11);

        // R8: valid held during busy with other values is ignored
        begin
            int cc0;
            cc0 = commit_cnt;
            xfer(8'h10, 8'h77, 8'd2, 1'b1);
            @(negedge clk);
            chk(req_ready === 1'b1, "R8", "no transfer started from busy request",
                int'(req_ready), 1);
            chk(phy_regs[8'hEF] == 8'h00, "R8", "stray code unwritten",
                int'(phy_regs[8'hEF]), 0);
            chk(commit_cnt - cc0 == 1, "R8", "single commit", commit_cnt - cc0, 1);
        end

        // R1: reset in the middle of a write
        req_valid = 1'b1;
        req_code  = 8'h30;
        req_data  = 8'h99;
        req_hold  = 8'd3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(tp_en === 1'b1, "R3", "mid-write enable high", int'(tp_en), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(tp_clk === 1'b1 && tp_en === 1'b0 && tp_din === 8'h00, "R1", "pins after mid-write reset",
            int'({tp_clk, tp_en, tp_din}), 'h200);
        chk(req_ready === 1'b1 && done === 1'b0, "R1", "ready/done after mid-write reset",
            int'({req_ready, done}), 2);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(phy_regs[8'h30] == 8'h00, "R1", "abandoned write not committed",
            int'(phy_regs[8'h30]), 0);
        xfer(8'h30, 8'h5D, 8'd1, 1'b0);

        summary();
        $finish;
    end
endmodule